// File: doc/BRIEF.md
# Bit-Reversed Input Reorder Buffer

This block sits at the input of a streaming radix-2 FFT. Complex samples arrive as 32-bit stream words, one per clock at most. The block counts each sample's position inside the current frame and writes the sample to the bit-reversed form of that position. The first butterfly stage can then fetch the frame with plain ascending addresses.

Storage is one dual-port RAM holding two frame-sized banks. The producer fills one bank while the consumer reads the other. Back-to-back frames are therefore accepted with no idle cycle at the frame boundary.

The consumer learns that a whole frame is waiting through a ready flag. It reads words through an address/data port with one cycle of latency and hands the bank back with a release pulse. The stream is held off only when both banks hold frames that have not been released. The frame length is a power-of-two parameter; 256, 1024 and 4096 are typical values.

Top module: `bitrev_reorder_buf`

## Requirements
- R1: The stream word carries the real part in bits [15:0] and the imaginary part in bits [31:16], both signed two's complement. The word is stored and returned unchanged.
- R2: The sample with position k in its frame (k counted from 0) is stored at the address whose LOG2N bits are those of k in reverse order. Reading address a therefore returns the sample at position bitrev(a).
- R3: `rd_data` shows the word at `rd_addr` one clock after the edge that samples `rd_addr`.
- R4: While a bank is free, `s_tready` stays high, including across frame boundaries. One sample is accepted on every clock with `s_tvalid` high.
- R5: `frame_ready` rises in the cycle after the edge that accepts the sample at position N-1.
- R6: `s_tready` is low exactly when both banks hold unreleased frames. A word offered while `s_tready` is low is neither stored nor counted.
- R7: A `frame_release` pulse while `frame_ready` is high frees the oldest frame. `s_tready` is high in the next cycle. A `frame_release` while `frame_ready` is low has no effect.
- R8: Frames reach the read port in the order in which they were written.
- R9: An accepted word whose `s_tlast` differs from (position == N-1) sets `frame_err`. The flag stays set until reset. Frame boundaries always follow the position counter.
- R10: A synchronous reset clears the position counter, both bank pointers, both full flags and `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | 32 | Sample word: imaginary [31:16], real [15:0] |
| s_tvalid | input | 1 | Sample offered |
| s_tready | output | 1 | Sample can be accepted |
| s_tlast | input | 1 | Producer marks the final sample of a frame |
| rd_addr | input | LOG2N | Read address inside the ready frame |
| rd_data | output | 32 | Word at the previous cycle's read address |
| frame_ready | output | 1 | A complete frame waits in the read bank |
| frame_release | input | 1 | Consumer hands the read bank back |
| frame_err | output | 1 | Sticky tlast/position mismatch flag |

## Verification
The assertions assume that reset is asserted before the first real traffic. The stream may offer words while `s_tready` is low, and `frame_release` may arrive at any time; the bench exercises both.

The bench drives all inputs on the falling edge, so no input changes at a sampling edge. The random phase uses gaps in `s_tvalid` and consumer delays long enough to fill both banks, so both the stalled and the free-running cases occur. Correct `s_tlast` is sent everywhere except in one directed mismatch case.

// File: rtl/brr_pkg.sv
package brr_pkg;

    // One complex sample as carried on the stream and held in the RAM.
    typedef struct packed {
        logic signed [15:0] im;
        logic signed [15:0] re;
    } cplx_t;

    localparam int SAMPLE_W = $bits(cplx_t);

endpackage

// File: rtl/brr_dpram.sv
module brr_dpram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/brr_ctrl.sv
module brr_ctrl #(
    parameter int N_POINTS = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          in_last,
    input  logic                          release_req,
    output logic                          in_ready,
    output logic                          wr_en,
    output logic [$clog2(N_POINTS):0]     wr_addr,
    output logic                          rd_bank,
    output logic                          frame_ready,
    output logic                          frame_err
);
    localparam int IDX_W = $clog2(N_POINTS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_POINTS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             wr_bank;
        logic             rd_bank;
        logic [1:0]       full;
        logic             err;
    } state_t;

    state_t st_d, st_q;
    logic   beat;
    logic   at_last;
    logic   rel_ok;
    logic [IDX_W-1:0] rev_idx;

    // Write address permutation: bit b of the position lands on bit IDX_W-1-b.
    for (genvar b = 0; b < IDX_W; b++) begin : g_rev
        assign rev_idx[b] = st_q.idx[IDX_W-1-b];
    end

    assign in_ready = !st_q.full[st_q.wr_bank];
    assign beat     = in_valid && in_ready;
    assign at_last  = (st_q.idx == LAST_IDX);
    assign rel_ok   = release_req && st_q.full[st_q.rd_bank];

    always_comb begin
        st_d = st_q;
        if (rel_ok) begin
            st_d.full[st_q.rd_bank] = 1'b0;
            st_d.rd_bank            = ~st_q.rd_bank;
        end
        if (beat) begin
            st_d.idx = st_q.idx + 1'b1;
            if (in_last != at_last) begin
                st_d.err = 1'b1;
            end
            if (at_last) begin
                st_d.full[st_q.wr_bank] = 1'b1;
                st_d.wr_bank            = ~st_q.wr_bank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en       = beat;
    assign wr_addr     = {st_q.wr_bank, rev_idx};
    assign rd_bank     = st_q.rd_bank;
    assign frame_ready = st_q.full[st_q.rd_bank];
    assign frame_err   = st_q.err;

endmodule

// File: rtl/bitrev_reorder_buf.sv
module bitrev_reorder_buf #(
    parameter int N_POINTS = 256,
    localparam int LOG2N   = $clog2(N_POINTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tlast,
    input  logic [LOG2N-1:0] rd_addr,
    output logic [31:0]      rd_data,
    output logic             frame_ready,
    input  logic             frame_release,
    output logic             frame_err
);
    localparam int RAM_AW = LOG2N + 1;

    brr_pkg::cplx_t    in_word;
    logic              wr_en;
    logic [RAM_AW-1:0] wr_addr;
    logic              rd_bank;
    logic [RAM_AW-1:0] rd_full_addr;

    assign in_word      = brr_pkg::cplx_t'(s_tdata);
    assign rd_full_addr = {rd_bank, rd_addr};

    brr_ctrl #(
        .N_POINTS (N_POINTS)
    ) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (s_tvalid),
        .in_last     (s_tlast),
        .release_req (frame_release),
        .in_ready    (s_tready),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_bank     (rd_bank),
        .frame_ready (frame_ready),
        .frame_err   (frame_err)
    );

    brr_dpram #(
        .AW (RAM_AW),
        .DW (brr_pkg::SAMPLE_W)
    ) i_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (in_word),
        .raddr (rd_full_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/brr_checker.sv
module brr_checker (
    input logic clk,
    input logic rst,
    input logic s_tready,
    input logic frame_ready,
    input logic frame_release,
    input logic frame_err
);
    AST_FREE_BANK_READY: assert property (@(posedge clk) disable iff (rst)
        !frame_ready |-> s_tready); // R6
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (rst)
        (frame_release && frame_ready) |=> s_tready); // R7
    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (frame_ready && !frame_release) |=> frame_ready); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (s_tready && !frame_ready && !frame_err)); // R10
endmodule

bind bitrev_reorder_buf brr_checker i_brr_checker (
    .clk           (clk),
    .rst           (rst),
    .s_tready      (s_tready),
    .frame_ready   (frame_ready),
    .frame_release (frame_release),
    .frame_err     (frame_err)
);

// File: tb/test_bitrev_reorder_buf.sv
module test_bitrev_reorder_buf;
    localparam int N  = 16;
    localparam int AW = 4;
    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tlast = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          frame_ready;
    logic          frame_release = 1'b0;
    logic          frame_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] frames [NF][N];
    bit fr_seen;
    bit stalled;

    always #5 clk = ~clk;

    bitrev_reorder_buf #(.N_POINTS(N)) i_bitrev_reorder_buf (
        .clk           (clk),
        .rst           (rst),
        .s_tdata       (s_tdata),
        .s_tvalid      (s_tvalid),
        .s_tready      (s_tready),
        .s_tlast       (s_tlast),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .frame_ready   (frame_ready),
        .frame_release (frame_release),
        .frame_err     (frame_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int brev(input int k);
        int r = 0;
        for (int b = 0; b < AW; b++) begin
            if (k[b]) r |= 1 << (AW - 1 - b);
        end
        return r;
    endfunction

    // Offer one word and wait until the edge that takes it.
    task automatic push(input logic [31:0] d, input bit l);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = d;
        s_tlast  = l;
        fr_seen  = frame_ready;
        stalled  = !s_tready;
        while (!s_tready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic read_frame(input int f, input string req);
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            @(negedge clk);
            chk(rd_data == frames[f][brev(a)], req, "frame word", rd_data, frames[f][brev(a)]);
        end
    endtask

    task automatic release_bank();
        @(negedge clk);
        frame_release = 1'b1;
        @(negedge clk);
        frame_release = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int f = 0; f < NF; f++) begin
            for (int k = 0; k < N; k++) begin
                if (f < 3) frames[f][k] = {16'(-(k + 1) * (f + 1)), 16'(k * 3 + f * 100 - 20)};
                else       frames[f][k] = $urandom;
            end
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(s_tready == 1'b1, "R10", "tready after reset", 32'(s_tready), 1);
        chk(frame_ready == 1'b0, "R10", "frame_ready after reset", 32'(frame_ready), 0);
        chk(frame_err == 1'b0, "R10", "frame_err after reset", 32'(frame_err), 0);

        // Two frames back to back with no idle cycle at the boundary.
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < N; k++) begin
                push(frames[f][k], k == N - 1);
                chk(!stalled, "R4", "no stall while a bank is free", 32'(stalled), 0);
                if (f == 0 && k == N - 1)
                    chk(fr_seen == 1'b0, "R5", "frame_ready before last beat", 32'(fr_seen), 0);
                if (f == 1 && k == 0)
                    chk(fr_seen == 1'b1, "R5", "frame_ready after last beat", 32'(fr_seen), 1);
            end
        end

        // Both banks full: the offered junk word must be refused.
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = 32'hDEAD_BEEF;
        s_tlast  = 1'b0;
        chk(s_tready == 1'b0, "R6", "tready with both banks full", 32'(s_tready), 0);
        repeat (3) @(negedge clk);
        chk(s_tready == 1'b0, "R6", "tready still low", 32'(s_tready), 0);
        s_tvalid = 1'b0;

        // R1: real and imaginary fields of the word at address 1 (position N/2).
        @(negedge clk);
        rd_addr = AW'(1);
        @(negedge clk);
        chk($signed(rd_data[15:0]) == 16'(N / 2 * 3 - 20), "R1", "real field", 32'(rd_data[15:0]), 32'(N / 2 * 3 - 20));
        chk($signed(rd_data[31:16]) == 16'(-(N / 2 + 1)), "R1", "imag field", 32'(rd_data[31:16]), 32'(16'(-(N / 2 + 1))));
        // R3: address change shows on rd_data one cycle later.
        rd_addr = AW'(0);
        @(posedge clk);
        #1;
        chk(rd_data == frames[0][0], "R3", "one-cycle read latency", rd_data, frames[0][0]);

        read_frame(0, "R2");
        release_bank();
        chk(frame_ready == 1'b1, "R7", "second frame ready after release", 32'(frame_ready), 1);
        chk(s_tready == 1'b1, "R7", "tready after release", 32'(s_tready), 1);
        read_frame(1, "R8");
        release_bank();
        chk(frame_ready == 1'b0, "R7", "no frame after second release", 32'(frame_ready), 0);
        chk(frame_err == 1'b0, "R6", "refused junk not counted", 32'(frame_err), 0);

        // Release with nothing ready must not move the read bank.
        release_bank();
        for (int k = 0; k < N; k++) push(frames[2][k], k == N - 1);
        idle();
        chk(frame_ready == 1'b1, "R7", "ignored release keeps bank order", 32'(frame_ready), 1);
        read_frame(2, "R7");
        release_bank();

        // Random traffic with gaps and slow consumer.
        fork
            begin
                for (int f = 3; f < NF; f++) begin
                    for (int k = 0; k < N; k++) begin
                        if ($urandom % 4 == 0) idle();
                        push(frames[f][k], k == N - 1);
                    end
                end
                idle();
            end
            begin
                for (int f = 3; f < NF; f++) begin
                    @(negedge clk);
                    while (!frame_ready) @(negedge clk);
                    repeat ($urandom % 40) @(negedge clk);
                    read_frame(f, "R8");
                    release_bank();
                end
            end
        join
        chk(frame_err == 1'b0, "R9", "no error on correct tlast", 32'(frame_err), 0);

        // tlast on position 0 is a mismatch.
        push(32'h0000_0001, 1'b1);
        idle();
        chk(frame_err == 1'b1, "R9", "mismatch sets flag", 32'(frame_err), 1);
        for (int k = 0; k < 3; k++) push(32'(k), 1'b0);
        idle();
        chk(frame_err == 1'b1, "R9", "flag sticky", 32'(frame_err), 1);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_err == 1'b0, "R10", "reset clears error", 32'(frame_err), 0);
        chk(frame_ready == 1'b0, "R10", "reset clears ready", 32'(frame_ready), 0);
        chk(s_tready == 1'b1, "R10", "reset frees banks", 32'(s_tready), 1);

        // Position counter restarts at 0: a full frame after reset is well framed.
        for (int k = 0; k < N; k++) push(frames[5][k], k == N - 1);
        idle();
        chk(frame_ready == 1'b1 && frame_err == 1'b0, "R10", "counter restarted",
            {30'b0, frame_ready, frame_err}, 32'h2);
        read_frame(5, "R10");

        summary();
        $finish;
    end
endmodule